// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits next to a simple in-order processor pipeline and takes care of switching into and out of exception handlers. Each cycle it looks at four kinds of request: a soft reset request, a general exception (faults raised by the instruction in flight, each with a 12-bit cause code), an interrupt (with a 12-bit event code), and a return-from-handler command. The pipeline also supplies its current program counter, its status word and a strobe that marks the end of an instruction.

When a request is accepted, the block saves the interrupted context, records the event code and computes the new status word. It also emits a one-cycle redirect pulse that carries the fetch target and the status word the pipeline must load. All of this commits on the same clock edge. General exceptions are taken straight away and abandon the faulting instruction. Interrupts wait for the instruction-end strobe, and they are held off while the status word's block bit is set. A return command redirects to the saved context.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `redirect_valid`, `redirect_kind`, `saved_pc`, `saved_sr` and all three event registers read zero.
- R2: When several requests are present in one cycle, exactly one is accepted, in this order: `reset_req` first, then `gexc_req`, then `rte_req`, then an eligible interrupt.
- R3: A general exception is accepted whatever the values of `insn_done` and the block bit. Its redirect target is `vec_base + 0x100`.
- R4: An interrupt is accepted only when `insn_done` is 1 and `cur_sr` bit 28 (block) is 0. Its redirect target is `vec_base + 0x600`. When it is not eligible, nothing is redirected.
- R5: On acceptance of a general exception or an interrupt, `saved_pc` takes `cur_pc` and `saved_sr` takes `cur_sr`.
- R6: On general exception or interrupt entry, `redirect_sr` equals `cur_sr` with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block) forced to 1. All other bits are unchanged.
- R7: A general exception writes its code into `exp_event[11:0]`. An interrupt writes its code into both `int_event[11:0]` and `int_event2[11:0]`. Each class leaves the other class's registers unchanged. Bits 31:12 of all three registers always read zero.
- R8: An accepted return command sets `redirect_pc` to `saved_pc` and `redirect_sr` to `saved_sr`. The saved registers and the event registers are left unchanged.
- R9: An accepted soft reset redirects to the fixed target 0xA000_0000 with status word 0x7000_00F0 and writes code 0x000 into `exp_event`. `saved_pc` and `saved_sr` keep their values.
- R10: `redirect_valid` is high for exactly the one cycle after an accepted request, and only then. `redirect_kind` then encodes the class: 1 reset, 2 general exception, 3 interrupt, 4 return. Otherwise `redirect_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Soft reset request |
| gexc_req | input | 1 | General exception request |
| gexc_code | input | 12 | Cause code of the general exception |
| irq_req | input | 1 | Interrupt request (already arbitrated) |
| irq_code | input | 12 | Event code of the interrupt |
| insn_done | input | 1 | Instruction boundary strobe |
| rte_req | input | 1 | Return-from-handler command |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word |
| vec_base | input | 32 | Vector base address |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_kind | output | 3 | Class of the accepted request |
| redirect_pc | output | 32 | Fetch target |
| redirect_sr | output | 32 | Status word to load |
| saved_pc | output | 32 | Saved program counter |
| saved_sr | output | 32 | Saved status word |
| exp_event | output | 32 | General exception event register |
| int_event | output | 32 | Interrupt event register |
| int_event2 | output | 32 | Second interrupt event register |

## Verification
The hardest case to reach is the one where request classes collide while the block bit and the instruction boundary are in every combination. For example, an interrupt can be pending on a boundary while a general exception or a return arrives in the same cycle. The bench sweeps all 64 combinations of the four request lines, the boundary strobe and the block bit, using a new PC, status word, base and codes for each combination. After every step it compares the redirect outputs and all saved and event registers against a model. That model carries the saved context forward, so every return step checks whatever context the last entry left behind.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int CODE_W = 12;

    // Status word control bit positions
    localparam int SR_MD = 30;
    localparam int SR_RB = 29;
    localparam int SR_BL = 28;

    // Vector offsets from the base
    localparam logic [XLEN-1:0] VEC_GEXC_OFS = 32'h0000_0100;
    localparam logic [XLEN-1:0] VEC_IRQ_OFS  = 32'h0000_0600;

    // Number of interrupt event registers written together
    localparam int NUM_INT_EVT = 2;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_RESET = 3'd1,
        EV_GEXC  = 3'd2,
        EV_IRQ   = 3'd3,
        EV_RTE   = 3'd4
    } ev_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] sr;
    } ctx_t;

    // Status word loaded on handler entry
    function automatic logic [XLEN-1:0] entry_sr(input logic [XLEN-1:0] sr);
        logic [XLEN-1:0] r;
        r        = sr;
        r[SR_MD] = 1'b1;
        r[SR_RB] = 1'b1;
        r[SR_BL] = 1'b1;
        return r;
    endfunction

    function automatic logic [XLEN-1:0] zext_code(input logic [CODE_W-1:0] c);
        return {{(XLEN-CODE_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic     reset_req,
    input  logic     gexc_req,
    input  logic     rte_req,
    input  logic     irq_req,
    input  logic     insn_done,
    input  logic     blocked,
    output ev_kind_e kind
);
    logic irq_ok;

    // Interrupts need a completed instruction and an open block bit
    assign irq_ok = irq_req && insn_done && !blocked;

    always_comb begin
        if (reset_req)     kind = EV_RESET;
        else if (gexc_req) kind = EV_GEXC;
        else if (rte_req)  kind = EV_RTE;
        else if (irq_ok)   kind = EV_IRQ;
        else               kind = EV_NONE;
    end
endmodule

// File: rtl/exc_ctx_store.sv
module exc_ctx_store
    import exc_entry_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  ev_kind_e          kind,
    input  ctx_t              cur,
    input  logic [CODE_W-1:0] gexc_code,
    input  logic [CODE_W-1:0] irq_code,
    output ctx_t              saved,
    output logic [CODE_W-1:0] exp_code,
    output logic [CODE_W-1:0] int_code [NUM_INT_EVT]
);
    logic take_ctx;
    assign take_ctx = (kind == EV_GEXC) || (kind == EV_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            saved <= '0;
        end else if (take_ctx) begin
            saved <= cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_code <= '0;
        end else if (kind == EV_GEXC) begin
            exp_code <= gexc_code;
        end else if (kind == EV_RESET) begin
            exp_code <= RESET_CODE;
        end
    end

    for (genvar g = 0; g < NUM_INT_EVT; g++) begin : g_int_evt
        always_ff @(posedge clk) begin
            if (rst) begin
                int_code[g] <= '0;
            end else if (kind == EV_IRQ) begin
                int_code[g] <= irq_code;
            end
        end
    end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0] RESET_SR = 32'h7000_00F0
) (
    input  logic            clk,
    input  logic            rst,
    input  ev_kind_e        kind,
    input  ctx_t            cur,
    input  ctx_t            saved,
    input  logic [XLEN-1:0] vec_base,
    output logic            valid,
    output ev_kind_e        kind_q,
    output ctx_t            target
);
    ctx_t nxt;

    always_comb begin
        nxt = '0;
        case (kind)
            EV_RESET: begin
                nxt.pc = RESET_PC;
                nxt.sr = RESET_SR;
            end
            EV_GEXC: begin
                nxt.pc = vec_base + VEC_GEXC_OFS;
                nxt.sr = entry_sr(cur.sr);
            end
            EV_IRQ: begin
                nxt.pc = vec_base + VEC_IRQ_OFS;
                nxt.sr = entry_sr(cur.sr);
            end
            EV_RTE: begin
                nxt = saved;
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            kind_q <= EV_NONE;
            target <= '0;
        end else begin
            valid  <= (kind != EV_NONE);
            kind_q <= kind;
            if (kind != EV_NONE) begin
                target <= nxt;
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] RESET_PC   = 32'hA000_0000,
    parameter logic [31:0] RESET_SR   = 32'h7000_00F0,
    parameter logic [11:0] RESET_CODE = 12'h000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reset_req,
    input  logic        gexc_req,
    input  logic [11:0] gexc_code,
    input  logic        irq_req,
    input  logic [11:0] irq_code,
    input  logic        insn_done,
    input  logic        rte_req,
    input  logic [31:0] cur_pc,
    input  logic [31:0] cur_sr,
    input  logic [31:0] vec_base,
    output logic        redirect_valid,
    output logic [2:0]  redirect_kind,
    output logic [31:0] redirect_pc,
    output logic [31:0] redirect_sr,
    output logic [31:0] saved_pc,
    output logic [31:0] saved_sr,
    output logic [31:0] exp_event,
    output logic [31:0] int_event,
    output logic [31:0] int_event2
);
    ev_kind_e          kind;
    ev_kind_e          kind_q;
    ctx_t              cur;
    ctx_t              saved;
    ctx_t              target;
    logic [CODE_W-1:0] exp_code;
    logic [CODE_W-1:0] int_code [NUM_INT_EVT];

    assign cur.pc = cur_pc;
    assign cur.sr = cur_sr;

    exc_arbiter u_arb (
        .reset_req (reset_req),
        .gexc_req  (gexc_req),
        .rte_req   (rte_req),
        .irq_req   (irq_req),
        .insn_done (insn_done),
        .blocked   (cur_sr[SR_BL]),
        .kind      (kind)
    );

    exc_ctx_store #(.RESET_CODE(RESET_CODE)) u_store (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .cur       (cur),
        .gexc_code (gexc_code),
        .irq_code  (irq_code),
        .saved     (saved),
        .exp_code  (exp_code),
        .int_code  (int_code)
    );

    exc_redirect #(.RESET_PC(RESET_PC), .RESET_SR(RESET_SR)) u_redir (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .cur      (cur),
        .saved    (saved),
        .vec_base (vec_base),
        .valid    (redirect_valid),
        .kind_q   (kind_q),
        .target   (target)
    );

    assign redirect_kind = kind_q;
    assign redirect_pc   = target.pc;
    assign redirect_sr   = target.sr;
    assign saved_pc      = saved.pc;
    assign saved_sr      = saved.sr;
    assign exp_event     = zext_code(exp_code);
    assign int_event     = zext_code(int_code[0]);
    assign int_event2    = zext_code(int_code[1]);
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
    parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        reset_req,
    input logic        gexc_req,
    input logic        irq_req,
    input logic        insn_done,
    input logic        rte_req,
    input logic [31:0] cur_pc,
    input logic [31:0] cur_sr,
    input logic [31:0] vec_base,
    input logic        redirect_valid,
    input logic [2:0]  redirect_kind,
    input logic [31:0] redirect_pc,
    input logic [31:0] redirect_sr,
    input logic [31:0] saved_pc,
    input logic [31:0] saved_sr,
    input logic [31:0] exp_event,
    input logic [31:0] int_event,
    input logic [31:0] int_event2
);
    logic idle_others;
    assign idle_others = !reset_req && !gexc_req && !rte_req;

    p_reset_first_r2: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> redirect_valid && redirect_kind == 3'd1);

    p_reset_target_r9: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> redirect_pc == RESET_PC && $stable(saved_pc) && $stable(saved_sr));

    p_gexc_vector_r3: assert property (@(posedge clk) disable iff (rst)
        (gexc_req && !reset_req) |=> redirect_kind == 3'd2
            && redirect_pc == $past(vec_base) + 32'h100);

    p_gexc_save_r5: assert property (@(posedge clk) disable iff (rst)
        (gexc_req && !reset_req) |=> saved_pc == $past(cur_pc) && saved_sr == $past(cur_sr));

    p_entry_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && (redirect_kind == 3'd2 || redirect_kind == 3'd3))
            |-> redirect_sr[30] && redirect_sr[29] && redirect_sr[28]);

    p_irq_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        (idle_others && (cur_sr[28] || !insn_done)) |=> !redirect_valid);

    p_irq_vector_r4: assert property (@(posedge clk) disable iff (rst)
        (idle_others && irq_req && insn_done && !cur_sr[28])
            |=> redirect_kind == 3'd3 && redirect_pc == $past(vec_base) + 32'h600);

    p_rte_restore_r8: assert property (@(posedge clk) disable iff (rst)
        (rte_req && !reset_req && !gexc_req)
            |=> redirect_pc == $past(saved_pc) && redirect_sr == $past(saved_sr)
                && $stable(saved_pc) && $stable(exp_event));

    p_code_width_r7: assert property (@(posedge clk) disable iff (rst)
        exp_event[31:12] == 20'd0 && int_event[31:12] == 20'd0 && int_event2[31:12] == 20'd0);

    p_kind_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !redirect_valid |-> redirect_kind == 3'd0);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.RESET_PC(RESET_PC)) u_chk (.*);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RST_PC = 32'hA000_0000;
    localparam logic [31:0] RST_SR = 32'h7000_00F0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_req = 1'b0, gexc_req = 1'b0, irq_req = 1'b0;
    logic        insn_done = 1'b0, rte_req = 1'b0;
    logic [11:0] gexc_code = '0, irq_code = '0;
    logic [31:0] cur_pc = '0, cur_sr = '0, vec_base = '0;
    logic        redirect_valid;
    logic [2:0]  redirect_kind;
    logic [31:0] redirect_pc, redirect_sr, saved_pc, saved_sr;
    logic [31:0] exp_event, int_event, int_event2;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model state
    logic [31:0] m_spc = '0, m_ssr = '0, m_exp = '0, m_int = '0;

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while in reset
        chk("R1 valid in reset", {31'd0, redirect_valid}, 32'd0);
        chk("R1 saved_pc in reset", saved_pc, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, redirect_valid}, 32'd0);
        chk("R1 kind after reset", {29'd0, redirect_kind}, 32'd0);
        chk("R1 saved_sr after reset", saved_sr, 32'd0);
        chk("R1 exp_event after reset", exp_event, 32'd0);
        chk("R1 int_event after reset", int_event, 32'd0);
        chk("R1 int_event2 after reset", int_event2, 32'd0);

        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 64; i++) begin
                logic r, g, t, q, d, b;
                int kind;
                logic [31:0] e_pc, e_sr, sr_in;
                r = i[5]; g = i[4]; t = i[3]; q = i[2]; d = i[1]; b = i[0];
                // fresh context for this step
                sr_in = ((32'h0123_4567 * (i + 3 + pass * 64)) ^ 32'h0000_00F0) & ~32'h1000_0000;
                sr_in = sr_in | ({31'd0, b} << 28);
                if (pass == 1) sr_in = sr_in & ~32'h6000_0000;
                reset_req = r; gexc_req = g; rte_req = t; irq_req = q; insn_done = d;
                cur_pc    = 32'h1000_0000 + 32'(i * 36 + pass * 4096);
                cur_sr    = sr_in;
                vec_base  = 32'h8000_0000 + (32'(i + pass) << 12);
                gexc_code = 12'(12'h040 + 12'(i * 32 + pass));
                irq_code  = 12'(12'h400 + 12'(i * 32 + pass * 3));

                if (r)                 kind = 1;
                else if (g)            kind = 2;
                else if (t)            kind = 4;
                else if (q && d && !b) kind = 3;
                else                   kind = 0;

                e_pc = '0; e_sr = '0;
                case (kind)
                    1: begin e_pc = RST_PC; e_sr = RST_SR; m_exp = 32'd0; end
                    2: begin
                        e_pc = vec_base + 32'h100; e_sr = sr_in | 32'h7000_0000;
                        m_spc = cur_pc; m_ssr = sr_in; m_exp = {20'd0, gexc_code};
                    end
                    3: begin
                        e_pc = vec_base + 32'h600; e_sr = sr_in | 32'h7000_0000;
                        m_spc = cur_pc; m_ssr = sr_in; m_int = {20'd0, irq_code};
                    end
                    4: begin e_pc = m_spc; e_sr = m_ssr; end
                    default: ;
                endcase

                @(negedge clk);
                chk("R10 valid pulse", {31'd0, redirect_valid}, {31'd0, kind != 0});
                chk("R2 accepted kind", {29'd0, redirect_kind}, 32'(kind));
                if (kind == 1) begin
                    chk("R9 reset target", redirect_pc, e_pc);
                    chk("R9 reset sr", redirect_sr, e_sr);
                end else if (kind == 2) begin
                    chk("R3 gexc target", redirect_pc, e_pc);
                    chk("R6 gexc entry sr", redirect_sr, e_sr);
                end else if (kind == 3) begin
                    chk("R4 irq target", redirect_pc, e_pc);
                    chk("R6 irq entry sr", redirect_sr, e_sr);
                end else if (kind == 4) begin
                    chk("R8 rte pc", redirect_pc, e_pc);
                    chk("R8 rte sr", redirect_sr, e_sr);
                end
                chk("R5 saved_pc", saved_pc, m_spc);
                chk("R5 saved_sr", saved_sr, m_ssr);
                chk("R7 exp_event", exp_event, m_exp);
                chk("R7 int_event", int_event, m_int);
                chk("R7 int_event2", int_event2, m_int);

                reset_req = 1'b0; gexc_req = 1'b0; rte_req = 1'b0; irq_req = 1'b0; insn_done = 1'b0;
                @(negedge clk);
                chk("R10 pulse ends", {31'd0, redirect_valid}, 32'd0);
                chk("R10 kind idle", {29'd0, redirect_kind}, 32'd0);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule